// File: doc/BRIEF.md
# Indirect Clock-Generator Register Port

This block is a byte-wide indirect window into a small bank of clock-generator control registers. A host bus reaches three byte locations: an address byte, a data byte and a clock-select byte. The address byte holds a register index and a write-enable flag. Reads and writes of the data byte then reach the register that the index names. A write into the bank needs the write-enable flag set in the address byte beforehand. A host that follows the usual sequence sets the flag, writes the data byte, then rewrites the address byte with the flag clear. A read writes the address byte with the flag clear and then reads the data byte.

The bank holds a post-divider register with one 2-bit field for each of four pixel clocks, four 8-bit feedback-divider registers at consecutive indices, and an extended-control register that carries one extended post-divider flag per clock in its upper nibble. The whole contents are driven out for the downstream clock logic. A 2-bit active clock index, kept in the clock-select byte, steers a second set of outputs: the post-divider field, the feedback divider and the extended flag that belong to the active clock. The analog PLL is not part of this block.

Top module: `clkreg_port`

## Requirements
- R1: An asynchronous active-low reset clears every register (address byte, clock index, post-divider, all feedback dividers, extended control), so every output and every readable byte reads zero.
- R2: Bus selector 0 is the address byte. A written byte stores bits [7:2] as the register index and bit 1 as the write-enable flag; a read returns {index, flag, 1'b0}, so bit 0 always reads zero. Selector 3 maps to nothing and reads zero.
- R3: Bus selector 1 is the data byte. A data write while the flag is set stores the byte in the register the index names; a data read returns that register whatever the flag.
- R4: A data write while the flag is clear changes no register in the bank.
- R5: The post-divider register sits at index 5 and packs four 2-bit fields, clock n at bits [2n+1:2n]; sel_post_div shows the field of the active clock.
- R6: The feedback-divider registers sit at indices 7, 8, 9 and 10 (base 7 plus the clock number), each 8 bits; fb_div_flat carries clock n at bits [8n+7:8n] and sel_fb_div shows the active clock's register.
- R7: The extended-control register sits at index 11 and all 8 bits are writable; bit 4+n is the extended post-divider flag of clock n, shown for the active clock on sel_ext_post, and the low nibble carries further control bits.
- R8: Bus selector 2 is the clock-select byte: a write keeps bits [1:0] as the active clock index, and a read returns the index in bits [1:0] with the upper six bits zero.
- R9: An index naming no register (for example 6 or 20) reads as zero on the data byte, and a data write to it, even with the flag set, changes no register.
- R10: A bus write takes effect at the clock edge on which bus_wr is sampled high; the register outputs keep their old value until that edge and show the new value after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the selected byte, one cycle per write |
| bus_sel | input | 2 | Byte selector: 0 address, 1 data, 2 clock select, 3 none |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data of the selected byte (combinational) |
| post_div_reg | output | 8 | Packed post-divider register |
| fb_div_flat | output | 32 | Four feedback-divider registers, clock 0 in the low byte |
| ext_ctl_reg | output | 8 | Extended-control register |
| clk_index | output | 2 | Active clock index |
| sel_post_div | output | 2 | Post-divider field of the active clock |
| sel_fb_div | output | 8 | Feedback divider of the active clock |
| sel_ext_post | output | 1 | Extended post-divider flag of the active clock |

## Verification
The bench builds the block with its default parameters: post-divider at index 5, feedback dividers from index 7, extended control at index 11, and a 6-bit index field. These defaults put a gap at index 6 and leave the indices above 11 free, so the unimplemented-index behaviour can be tested both between registers and beyond the bank. With four clocks and a different value loaded into every feedback divider and every packed field, each of the four clock indices steers to a distinct expected triple. A wrong field position or a wrong register slot therefore shows up at the ports.

// File: rtl/clkreg_pkg.sv
package clkreg_pkg;

  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned ADDR_LSB  = 2;   // index field starts here
  localparam int unsigned WE_BIT    = 1;   // write-enable flag position
  localparam int unsigned CIDX_W    = 2;   // clock index width
  localparam int unsigned NUM_CLK   = 1 << CIDX_W;
  localparam int unsigned FIELD_W   = 2;   // packed post-divider field
  localparam int unsigned EXT_BASE  = 4;   // first per-clock extended flag

  typedef enum logic [1:0] {
    HOST_ADDR   = 2'd0,
    HOST_DATA   = 2'd1,
    HOST_CLKSEL = 2'd2,
    HOST_NONE   = 2'd3
  } host_sel_e;

  // Field of clock n inside the packed post-divider byte.
  function automatic logic [FIELD_W-1:0] pick_post_field(
    input logic [BYTE_W-1:0] packed_byte,
    input logic [CIDX_W-1:0] n
  );
    logic [BYTE_W-1:0] shifted;
    shifted = packed_byte >> (FIELD_W * n);
    return shifted[FIELD_W-1:0];
  endfunction

  // Extended post-divider flag of clock n.
  function automatic logic pick_ext_flag(
    input logic [BYTE_W-1:0] ext_byte,
    input logic [CIDX_W-1:0] n
  );
    logic [BYTE_W-1:0] shifted;
    shifted = ext_byte >> (EXT_BASE + n);
    return shifted[0];
  endfunction

  // Byte of clock n inside the flattened feedback-divider vector.
  function automatic logic [BYTE_W-1:0] pick_fb_byte(
    input logic [NUM_CLK*BYTE_W-1:0] flat,
    input logic [CIDX_W-1:0]         n
  );
    logic [NUM_CLK*BYTE_W-1:0] shifted;
    shifted = flat >> (BYTE_W * n);
    return shifted[BYTE_W-1:0];
  endfunction

endpackage

// File: rtl/clkreg_host_if.sv
module clkreg_host_if
  import clkreg_pkg::*;
#(
  parameter int unsigned IDX_W = BYTE_W - ADDR_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_sel,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] addr_byte,
  output logic [IDX_W-1:0]  addr_index,
  output logic              addr_we,
  output logic [CIDX_W-1:0] clk_index,
  output logic [BYTE_W-1:0] clksel_byte,
  output logic              bank_wr_strobe
);

  logic [IDX_W-1:0]  idx_q;
  logic              we_q;
  logic [CIDX_W-1:0] cidx_q;
  logic              addr_write;
  logic              clksel_write;
  logic              data_write;

  assign addr_write   = bus_wr && (bus_sel == HOST_ADDR);
  assign clksel_write = bus_wr && (bus_sel == HOST_CLKSEL);
  assign data_write   = bus_wr && (bus_sel == HOST_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      we_q  <= 1'b0;
    end else if (addr_write) begin
      idx_q <= bus_wdata[BYTE_W-1:ADDR_LSB];
      we_q  <= bus_wdata[WE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cidx_q <= '0;
    end else if (clksel_write) begin
      cidx_q <= bus_wdata[CIDX_W-1:0];
    end
  end

  assign addr_index     = idx_q;
  assign addr_we        = we_q;
  assign addr_byte      = {idx_q, we_q, 1'b0};
  assign clk_index      = cidx_q;
  assign clksel_byte    = {{(BYTE_W-CIDX_W){1'b0}}, cidx_q};
  assign bank_wr_strobe = data_write && we_q;

endmodule

// File: rtl/clkreg_bank.sv
module clkreg_bank
  import clkreg_pkg::*;
#(
  parameter int unsigned IDX_W       = BYTE_W - ADDR_LSB,
  parameter int unsigned POSTDIV_IDX = 5,
  parameter int unsigned FBDIV_BASE  = 7,
  parameter int unsigned EXTCTL_IDX  = 11
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_strobe,
  input  logic [IDX_W-1:0]          index,
  input  logic [BYTE_W-1:0]         wr_data,
  output logic [BYTE_W-1:0]         post_div_reg,
  output logic [NUM_CLK*BYTE_W-1:0] fb_div_flat,
  output logic [BYTE_W-1:0]         ext_ctl_reg,
  output logic [BYTE_W-1:0]         rd_data,
  output logic                      index_hit,
  output logic [NUM_CLK-1:0]        fb_hit_vec
);

  localparam logic [IDX_W-1:0] POST_SEL = IDX_W'(POSTDIV_IDX);
  localparam logic [IDX_W-1:0] EXT_SEL  = IDX_W'(EXTCTL_IDX);

  logic post_hit;
  logic ext_hit;
  logic [BYTE_W-1:0] post_q;
  logic [BYTE_W-1:0] ext_q;
  logic [BYTE_W-1:0] fb_q [NUM_CLK];
  logic [BYTE_W-1:0] fb_rd;

  assign post_hit = (index == POST_SEL);
  assign ext_hit  = (index == EXT_SEL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      post_q <= '0;
    end else if (wr_strobe && post_hit) begin
      post_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q <= '0;
    end else if (wr_strobe && ext_hit) begin
      ext_q <= wr_data;
    end
  end

  for (genvar g = 0; g < NUM_CLK; g++) begin : g_fb
    assign fb_hit_vec[g] = (index == IDX_W'(FBDIV_BASE + g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fb_q[g] <= '0;
      end else if (wr_strobe && fb_hit_vec[g]) begin
        fb_q[g] <= wr_data;
      end
    end

    assign fb_div_flat[g*BYTE_W +: BYTE_W] = fb_q[g];
  end

  always_comb begin
    fb_rd = '0;
    for (int k = 0; k < NUM_CLK; k++) begin
      if (fb_hit_vec[k]) fb_rd = fb_q[k];
    end
  end

  always_comb begin
    if (post_hit)        rd_data = post_q;
    else if (ext_hit)    rd_data = ext_q;
    else if (|fb_hit_vec) rd_data = fb_rd;
    else                 rd_data = '0;
  end

  assign index_hit    = post_hit || ext_hit || (|fb_hit_vec);
  assign post_div_reg = post_q;
  assign ext_ctl_reg  = ext_q;

endmodule

// File: rtl/clkreg_steer.sv
module clkreg_steer
  import clkreg_pkg::*;
(
  input  logic [BYTE_W-1:0]         post_div_reg,
  input  logic [NUM_CLK*BYTE_W-1:0] fb_div_flat,
  input  logic [BYTE_W-1:0]         ext_ctl_reg,
  input  logic [CIDX_W-1:0]         clk_index,
  output logic [FIELD_W-1:0]        sel_post_div,
  output logic [BYTE_W-1:0]         sel_fb_div,
  output logic                      sel_ext_post
);

  assign sel_post_div = pick_post_field(post_div_reg, clk_index);
  assign sel_fb_div   = pick_fb_byte(fb_div_flat, clk_index);
  assign sel_ext_post = pick_ext_flag(ext_ctl_reg, clk_index);

endmodule

// File: rtl/clkreg_port.sv
module clkreg_port
  import clkreg_pkg::*;
#(
  parameter int unsigned POSTDIV_IDX = 5,
  parameter int unsigned FBDIV_BASE  = 7,
  parameter int unsigned EXTCTL_IDX  = 11
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic [1:0]                bus_sel,
  input  logic [BYTE_W-1:0]         bus_wdata,
  output logic [BYTE_W-1:0]         bus_rdata,
  output logic [BYTE_W-1:0]         post_div_reg,
  output logic [NUM_CLK*BYTE_W-1:0] fb_div_flat,
  output logic [BYTE_W-1:0]         ext_ctl_reg,
  output logic [CIDX_W-1:0]         clk_index,
  output logic [FIELD_W-1:0]        sel_post_div,
  output logic [BYTE_W-1:0]         sel_fb_div,
  output logic                      sel_ext_post
);

  localparam int unsigned IDX_W = BYTE_W - ADDR_LSB;

  // Internal events, named for the checker.
  logic [BYTE_W-1:0]  addr_byte;
  logic [IDX_W-1:0]   addr_index;
  logic               addr_we;
  logic [BYTE_W-1:0]  clksel_byte;
  logic               bank_wr_strobe;
  logic [BYTE_W-1:0]  bank_rdata;
  logic               bank_index_hit;
  logic [NUM_CLK-1:0] fb_hit_vec;

  clkreg_host_if #(.IDX_W(IDX_W)) u_host (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_wr         (bus_wr),
    .bus_sel        (bus_sel),
    .bus_wdata      (bus_wdata),
    .addr_byte      (addr_byte),
    .addr_index     (addr_index),
    .addr_we        (addr_we),
    .clk_index      (clk_index),
    .clksel_byte    (clksel_byte),
    .bank_wr_strobe (bank_wr_strobe)
  );

  clkreg_bank #(
    .IDX_W       (IDX_W),
    .POSTDIV_IDX (POSTDIV_IDX),
    .FBDIV_BASE  (FBDIV_BASE),
    .EXTCTL_IDX  (EXTCTL_IDX)
  ) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_strobe    (bank_wr_strobe),
    .index        (addr_index),
    .wr_data      (bus_wdata),
    .post_div_reg (post_div_reg),
    .fb_div_flat  (fb_div_flat),
    .ext_ctl_reg  (ext_ctl_reg),
    .rd_data      (bank_rdata),
    .index_hit    (bank_index_hit),
    .fb_hit_vec   (fb_hit_vec)
  );

  clkreg_steer u_steer (
    .post_div_reg (post_div_reg),
    .fb_div_flat  (fb_div_flat),
    .ext_ctl_reg  (ext_ctl_reg),
    .clk_index    (clk_index),
    .sel_post_div (sel_post_div),
    .sel_fb_div   (sel_fb_div),
    .sel_ext_post (sel_ext_post)
  );

  always_comb begin
    unique case (bus_sel)
      HOST_ADDR:   bus_rdata = addr_byte;
      HOST_DATA:   bus_rdata = bank_rdata;
      HOST_CLKSEL: bus_rdata = clksel_byte;
      default:     bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/clkreg_port_chk.sv
module clkreg_port_chk
  import clkreg_pkg::*;
#(
  parameter int unsigned POSTDIV_IDX = 5,
  parameter int unsigned IDX_W       = BYTE_W - ADDR_LSB
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_wr,
  input logic [1:0]                bus_sel,
  input logic [BYTE_W-1:0]         bus_wdata,
  input logic                      addr_we,
  input logic [IDX_W-1:0]          addr_index,
  input logic                      bank_wr_strobe,
  input logic                      bank_index_hit,
  input logic [NUM_CLK-1:0]        fb_hit_vec,
  input logic [BYTE_W-1:0]         post_div_reg,
  input logic [NUM_CLK*BYTE_W-1:0] fb_div_flat,
  input logic [BYTE_W-1:0]         ext_ctl_reg,
  input logic [CIDX_W-1:0]         clk_index
);

  // R1: held reset leaves the bank and the index at zero
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (post_div_reg == '0) && (fb_div_flat == '0) &&
               (ext_ctl_reg == '0) && (clk_index == '0));

  // R4: data write with the flag clear leaves the bank untouched
  assert_no_write_without_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == HOST_DATA && !addr_we) |=>
      $stable(post_div_reg) && $stable(fb_div_flat) && $stable(ext_ctl_reg));

  // R3, R5: an enabled write to the post-divider index lands there
  assert_post_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == HOST_DATA && addr_we && addr_index == IDX_W'(POSTDIV_IDX))
      |=> post_div_reg == $past(bus_wdata));

  // R9: a write to an index with no register changes nothing
  assert_unimpl_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_wr_strobe && !bank_index_hit) |=>
      $stable(post_div_reg) && $stable(fb_div_flat) && $stable(ext_ctl_reg));

  // R6: at most one feedback-divider slot decodes at a time
  assert_fb_decode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fb_hit_vec));

  // R8: the clock-select byte keeps the low two bits of a write
  assert_clk_index_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == HOST_CLKSEL) |=> clk_index == $past(bus_wdata[CIDX_W-1:0]));

  // R10: with no write strobe, the bank holds its value
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(post_div_reg) && $stable(fb_div_flat) &&
                $stable(ext_ctl_reg) && $stable(clk_index));

endmodule

bind clkreg_port clkreg_port_chk #(
  .POSTDIV_IDX (POSTDIV_IDX),
  .IDX_W       (IDX_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .bus_wr         (bus_wr),
  .bus_sel        (bus_sel),
  .bus_wdata      (bus_wdata),
  .addr_we        (addr_we),
  .addr_index     (addr_index),
  .bank_wr_strobe (bank_wr_strobe),
  .bank_index_hit (bank_index_hit),
  .fb_hit_vec     (fb_hit_vec),
  .post_div_reg   (post_div_reg),
  .fb_div_flat    (fb_div_flat),
  .ext_ctl_reg    (ext_ctl_reg),
  .clk_index      (clk_index)
);

// File: tb/tb_clkreg_port.sv
module tb_clkreg_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_sel = 2'd0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic [7:0]  post_div_reg;
  logic [31:0] fb_div_flat;
  logic [7:0]  ext_ctl_reg;
  logic [1:0]  clk_index;
  logic [1:0]  sel_post_div;
  logic [7:0]  sel_fb_div;
  logic        sel_ext_post;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  clkreg_port dut (
    .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_sel (bus_sel),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .post_div_reg (post_div_reg), .fb_div_flat (fb_div_flat),
    .ext_ctl_reg (ext_ctl_reg), .clk_index (clk_index),
    .sel_post_div (sel_post_div), .sel_fb_div (sel_fb_div),
    .sel_ext_post (sel_ext_post)
  );

  // Selector codes, restated from the requirements.
  localparam logic [1:0] S_A = 2'd0, S_D = 2'd1, S_C = 2'd2, S_N = 2'd3;

  // {read, selector, data-or-expected, requirement number}
  localparam int N_VEC = 24;
  localparam logic [14:0] VEC [N_VEC] = '{
    {1'b0, S_A, 8'h16, 4'd2},  // index 5, flag set (R2)
    {1'b0, S_D, 8'hE4, 4'd5},  // packed fields 3,2,1,0 (R5)
    {1'b1, S_D, 8'hE4, 4'd3},
    {1'b1, S_A, 8'h16, 4'd2},
    {1'b0, S_A, 8'h1E, 4'd6},  // index 7 (R6)
    {1'b0, S_D, 8'h81, 4'd6},
    {1'b0, S_A, 8'h22, 4'd6},
    {1'b0, S_D, 8'h92, 4'd6},
    {1'b0, S_A, 8'h26, 4'd6},
    {1'b0, S_D, 8'hA3, 4'd6},
    {1'b0, S_A, 8'h2A, 4'd6},
    {1'b0, S_D, 8'hB4, 4'd6},
    {1'b0, S_A, 8'h2E, 4'd7},  // index 11 (R7)
    {1'b0, S_D, 8'h5A, 4'd7},
    {1'b0, S_A, 8'h20, 4'd4},  // index 8, flag clear (R4)
    {1'b0, S_D, 8'hFF, 4'd4},
    {1'b1, S_D, 8'h92, 4'd4},
    {1'b0, S_A, 8'h2C, 4'd7},
    {1'b1, S_D, 8'h5A, 4'd7},
    {1'b0, S_A, 8'h1F, 4'd2},  // bit 0 is dropped
    {1'b1, S_A, 8'h1E, 4'd2},
    {1'b1, S_D, 8'h81, 4'd6},
    {1'b0, S_C, 8'hFE, 4'd8},  // only bits [1:0] kept (R8)
    {1'b1, S_C, 8'h02, 4'd8}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    bus_sel = sel; bus_wdata = data; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] sel, output logic [7:0] data);
    @(negedge clk);
    bus_sel = sel; bus_wr = 1'b0;
    #1 data = bus_rdata;
  endtask

  task automatic check_steer(input string req, input logic [1:0] exp_post,
                             input logic [7:0] exp_fb, input logic exp_ext);
    #1;
    check(req, "sel_post_div", 32'(sel_post_div), 32'(exp_post));
    check(req, "sel_fb_div", 32'(sel_fb_div), 32'(exp_fb));
    check(req, "sel_ext_post", 32'(sel_ext_post), 32'(exp_ext));
  endtask

  task automatic check_all_zero(input string req);
    logic [7:0] rd;
    check(req, "post_div_reg", 32'(post_div_reg), 32'h0);
    check(req, "fb_div_flat", fb_div_flat, 32'h0);
    check(req, "ext_ctl_reg", 32'(ext_ctl_reg), 32'h0);
    check(req, "clk_index", 32'(clk_index), 32'h0);
    bus_read(S_A, rd); check(req, "addr byte", 32'(rd), 32'h0);
    bus_read(S_D, rd); check(req, "data byte", 32'(rd), 32'h0);
    bus_read(S_C, rd); check(req, "clksel byte", 32'(rd), 32'h0);
  endtask

  initial begin : watchdog
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog (all requirements): actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    check_all_zero("R1");
    rst_n = 1'b1;

    // Table walk
    for (int i = 0; i < N_VEC; i++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[i][3:0]);
      if (VEC[i][14]) begin
        bus_read(VEC[i][13:12], rd);
        check(tag, $sformatf("vector %0d read", i), 32'(rd), 32'(VEC[i][11:4]));
      end else begin
        bus_write(VEC[i][13:12], VEC[i][11:4]);
      end
    end

    // R6, R5, R7: full register images
    check("R5", "post_div_reg", 32'(post_div_reg), 32'hE4);
    check("R6", "fb_div_flat", fb_div_flat, 32'hB4A39281);
    check("R7", "ext_ctl_reg", 32'(ext_ctl_reg), 32'h5A);

    // Steering by active clock: index 2 already selected
    check_steer("R5 R6 R7 clk2", 2'b10, 8'hA3, 1'b1);
    bus_write(S_C, 8'h01); check_steer("R5 R6 R7 clk1", 2'b01, 8'h92, 1'b0);
    bus_write(S_C, 8'h03); check_steer("R5 R6 R7 clk3", 2'b11, 8'hB4, 1'b0);
    bus_write(S_C, 8'h00); check_steer("R5 R6 R7 clk0", 2'b00, 8'h81, 1'b1);

    // R9: unimplemented indices 20 and 6
    bus_write(S_A, 8'h52);
    bus_write(S_D, 8'h77);
    bus_read(S_D, rd); check("R9", "index 20 read", 32'(rd), 32'h0);
    check("R9", "post_div_reg kept", 32'(post_div_reg), 32'hE4);
    check("R9", "fb_div_flat kept", fb_div_flat, 32'hB4A39281);
    check("R9", "ext_ctl_reg kept", 32'(ext_ctl_reg), 32'h5A);
    bus_write(S_A, 8'h1A);
    bus_write(S_D, 8'h33);
    bus_read(S_D, rd); check("R9", "index 6 read", 32'(rd), 32'h0);
    check("R9", "fb_div_flat kept idx6", fb_div_flat, 32'hB4A39281);

    // R2: selector 3 maps to nothing
    bus_read(S_N, rd); check("R2", "selector 3 read", 32'(rd), 32'h0);

    // R10: write visible only after the sampling edge
    bus_write(S_A, 8'h16);
    @(negedge clk);
    bus_sel = S_D; bus_wdata = 8'h1B; bus_wr = 1'b1;
    #1 check("R10", "before edge", 32'(post_div_reg), 32'hE4);
    @(negedge clk);
    bus_wr = 1'b0;
    check("R10", "after edge", 32'(post_div_reg), 32'h1B);

    // R1: reset in mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_all_zero("R1 mid-run");
    rst_n = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule